// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds an eight-stage shift register that software-free logic fills in one step from a parallel word and then empties one bit at a time toward a serial output. While the active-low load input is held low, every stage follows the parallel word, and the top stage appears on the serial output with no shift edge needed. Once load is released, each rising edge of the combined shift clock moves every stage one place toward the output. The combined shift clock is the logical OR of a clock pin and an inhibit pin. The first stage is refilled from a serial data pin on every shift.

The pins are sampled on a system clock, and the block keeps the previous level of the combined shift clock to find its rising edges. Because the shift clock is an OR, holding inhibit high hides clock edges. A rising inhibit while the clock pin is low is itself a shift edge. A simulation checker reports uses that break the two usage rules: inhibit should rise only while the clock pin is high, and both pins should be low when load is released. The checker never alters the register.

Top module: `plso_shifter`

## Requirements
- R1: After reset the serial output is 0 and the complementary output is 1.
- R2: While load is low, all stages take the parallel word on each system clock edge, whatever the clock and inhibit pins do. The next sample shows parallel bit 7 (the H input) on the serial output.
- R3: A rising edge of the combined shift clock while load is low causes no shift. The output keeps parallel bit 7.
- R4: With load high, a rising edge of (clock OR inhibit) moves stage i to stage i+1. The serial output is stage 7, so loading 8'b11010101 with serial input 0 gives the output sequence 1, then 1,0,1,0,1,0,1,0 after successive edges.
- R5: On each shift, stage 0 takes the serial input, so after eight shifts following a load the output shows the first serial bit shifted in.
- R6: While inhibit is high, edges on the clock pin cause no shift.
- R7: A rising inhibit while the clock pin is low is a shift edge and shifts once.
- R8: Falling edges and steady levels of the combined shift clock leave the stages unchanged.
- R9: The complementary output is always the inverse of the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_pin | input | 1 | Shift clock pin |
| inh_pin | input | 1 | Clock inhibit pin, ORed with the shift clock |
| load_n | input | 1 | Active-low parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 is the H input |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Inverse of the last stage |

## Verification
The shift path is tried with two load patterns. The alternating word 11010101 with the serial input at 0 tells a correct single-place shift apart from a skipped or doubled edge. An all-zero word with the serial input at 1 shows the exact edge on which serial data first reaches the output. Clock pulses are applied with load low and with inhibit high to separate the load and inhibit overrides from a real shift. A bare inhibit rise with the clock pin low shows that the OR'd edge shifts, and idle falling edges show that only rising edges count.

// File: rtl/plso_pkg.sv
package plso_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } plso_act_e;
endpackage

// File: rtl/plso_gate.sv
module plso_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic inh_pin,
    output logic gate_rise
);
    typedef struct packed {
        logic level;
    } gate_st_t;

    gate_st_t gate_d, gate_q;
    logic     gate_now;

    always_comb begin
        gate_now     = sclk_pin | inh_pin;
        gate_d.level = gate_now;
        gate_rise    = gate_now & ~gate_q.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q.level <= 1'b1;
        end else begin
            gate_q <= gate_d;
        end
    end
endmodule

// File: rtl/plso_stages.sv
module plso_stages #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  plso_pkg::plso_act_e  act,
    input  logic [WIDTH-1:0]     par_in,
    input  logic                 ser_in,
    output logic [WIDTH-1:0]     stages
);
    import plso_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD:  st_d.bits = par_in;
            ACT_SHIFT: st_d.bits = {st_q.bits[WIDTH-2:0], ser_in};
            default:   st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.bits;
endmodule

// File: rtl/plso_shifter.sv
module plso_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_pin,
    input  logic             inh_pin,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_out,
    output logic             q_out_n
);
    import plso_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic               gate_rise;
    plso_act_e          act;
    logic [WIDTH-1:0]   stages_q;

    plso_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (sclk_pin),
        .inh_pin   (inh_pin),
        .gate_rise (gate_rise)
    );

    // load wins over any shift edge
    always_comb begin
        if (!load_n) begin
            act = ACT_LOAD;
        end else if (gate_rise) begin
            act = ACT_SHIFT;
        end else begin
            act = ACT_HOLD;
        end
    end

    plso_stages #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .par_in (par_in),
        .ser_in (ser_in),
        .stages (stages_q)
    );

    assign q_out   = stages_q[MSB];
    assign q_out_n = ~stages_q[MSB];
endmodule

// File: rtl/plso_checker.sv
module plso_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_pin,
    input logic             inh_pin,
    input logic             load_n,
    input logic [WIDTH-1:0] par_in,
    input logic             q_out,
    input logic             q_out_n,
    input logic [WIDTH-1:0] stages
);
    logic gate;
    logic inh_prev, load_prev;

    assign gate = sclk_pin | inh_pin;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_prev  <= 1'b1;
            load_prev <= 1'b1;
        end else begin
            inh_prev  <= inh_pin;
            load_prev <= load_n;
            if (inh_pin && !inh_prev && !sclk_pin)
                $display("rule warning: inhibit rose while clock pin low (%0t)", $time);
            if (load_n && !load_prev && gate)
                $display("rule warning: load released with clock or inhibit high (%0t)", $time);
        end
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q_out == $past(par_in[WIDTH-1])));

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && gate && !$past(gate) && $past(rst_n)) |=> (q_out == $past(stages[WIDTH-2])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(gate && !$past(gate)) && $past(rst_n)) |=> $stable(stages));

    assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_out_n == ~q_out);
endmodule

bind plso_shifter plso_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_pin (sclk_pin),
    .inh_pin  (inh_pin),
    .load_n   (load_n),
    .par_in   (par_in),
    .q_out    (q_out),
    .q_out_n  (q_out_n),
    .stages   (stages_q)
);

// File: tb/sim_plso_shifter.sv
`timescale 1ns/1ps
module sim_plso_shifter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_pin = 1'b0;
    logic         inh_pin = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         q_out, q_out_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    plso_shifter #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .inh_pin(inh_pin),
        .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
        .q_out(q_out), .q_out_n(q_out_n)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        sclk_pin = 1'b0; inh_pin = 1'b0;
        par_in = v; load_n = 1'b0; settle();
        check(q_out, v[W-1], "R2");
        load_n = 1'b1; settle();
        check(q_out, v[W-1], "R2");
    endtask

    task automatic sclk_pulse();
        sclk_pin = 1'b1; settle();
        sclk_pin = 1'b0; settle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; settle(); settle();
        rst_n = 1'b1; settle();
        check(q_out, 1'b0, "R1");
        check(q_out_n, 1'b1, "R1");
    endtask

    task automatic t_sequence();
        logic [W-1:0] v = 8'b1101_0101;
        ser_in = 1'b0;
        do_load(v);
        for (int i = 0; i < W; i++) begin
            logic exp = (i < W - 1) ? v[W-2-i] : 1'b0;
            sclk_pin = 1'b1; settle();
            check(q_out, exp, (i == W - 1) ? "R5" : "R4");
            check(q_out_n, ~exp, "R9");
            sclk_pin = 1'b0; settle();
            check(q_out, exp, "R8");
        end
    endtask

    task automatic t_serial_fill();
        ser_in = 1'b1;
        do_load(8'h00);
        for (int i = 0; i < W - 1; i++) sclk_pulse();
        check(q_out, 1'b0, "R5");
        sclk_pulse();
        check(q_out, 1'b1, "R5");
        ser_in = 1'b0;
    endtask

    task automatic t_load_priority();
        par_in = 8'h80; load_n = 1'b0; settle();
        sclk_pin = 1'b1; settle();
        check(q_out, 1'b1, "R3");
        sclk_pin = 1'b0; settle();
        par_in = 8'h7F; settle();
        check(q_out, 1'b0, "R2");
        sclk_pin = 1'b1; settle(); sclk_pin = 1'b0; settle();
        load_n = 1'b1; settle();
        check(q_out, 1'b0, "R3");
        sclk_pulse();
        check(q_out, 1'b1, "R4");
    endtask

    task automatic t_inhibit();
        do_load(8'hA0);
        sclk_pin = 1'b1; settle();
        inh_pin = 1'b1; settle();
        sclk_pin = 1'b0; settle();
        check(q_out, 1'b0, "R4");
        for (int i = 0; i < 3; i++) sclk_pulse();
        check(q_out, 1'b0, "R6");
        sclk_pin = 1'b1; settle();
        inh_pin = 1'b0; settle();
        sclk_pin = 1'b0; settle();
        check(q_out, 1'b0, "R8");
    endtask

    task automatic t_inh_edge();
        do_load(8'hA0);
        inh_pin = 1'b1; settle();
        check(q_out, 1'b0, "R7");
        inh_pin = 1'b0; settle();
        check(q_out, 1'b0, "R8");
        sclk_pulse();
        check(q_out, 1'b1, "R7");
        check(q_out_n, 1'b0, "R9");
    endtask

    initial begin
        settle();
        t_reset();
        t_sequence();
        t_serial_fill();
        t_load_priority();
        t_inhibit();
        t_inh_edge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule